// File: doc/BRIEF.md
# Layer-Tagged Ternary Prefix Match Array

This block is a small ternary match array for longest-prefix routing lookups. Each entry holds a W-bit prefix stored as ternary cells (value plus care mask), a 4-bit layer tag held in four more ternary columns placed directly above the prefix columns, a valid bit, and a side-table field that records the entry's prefix length. A search presents a key, a query length and a layer selector. The block turns the query length and layer selector into a global column mask and compares the masked key against every valid entry in parallel. It returns a hit flag and the index of the lowest-addressed matching entry.

Entries are written and read by index through a separate port. A search completes in one cycle and a read in one cycle. A write occupies the array for three cycles. During those three cycles the block raises `busy` and refuses searches and further writes, so a search result never reflects a partly written entry. An upper layer of software places entries so that the lowest matching index is the wanted answer. That placement policy lies outside this block.

Top module: `layer_tcam`

## Requirements
- R1: After reset every entry is invalid, `busy` and `resValid` are low, and a search misses with `resIdx` 0.
- R2: A written entry reads back its value and care bits. A don't-care bit reads back as care 0 and value 0. A stored don't-care bit matches a key bit of either value.
- R3: The query length selects the compared prefix columns. With length L only the top L key bits (bit W-1 downward) take part. Length 0 compares no prefix bit, and any length of W or more compares all W bits.
- R4: Layer selector 0 ignores the tag columns, so every layer is searched. A nonzero selector only matches entries whose 4-bit tag equals it.
- R5: When several entries match, `resIdx` is the lowest matching index.
- R6: An entry whose valid bit is clear never matches.
- R7: A search accepted at a clock edge raises `resValid` for exactly the following cycle, with `resHit` and `resIdx` valid in that cycle.
- R8: A write accepted at an edge holds `busy` high for exactly the three following cycles. The new contents are searchable and readable in the cycle `busy` falls.
- R9: A search or write presented while `busy` is high is ignored. No result appears and no entry changes.
- R10: A read accepted at an edge returns data with `rdDataValid` high in the next cycle. During an unfinished write it returns the old contents.
- R11: Each entry's prefix-length side-table field is written with the entry and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srchEn | input | 1 | Search request |
| srchKey | input | W | Search key |
| srchLen | input | LEN_W | Query length in bits |
| srchLayer | input | 4 | Layer selector, 0 = all layers |
| wrEn | input | 1 | Write request |
| wrIdx | input | IDX_W | Entry index to write |
| wrValue | input | W | Prefix value bits |
| wrCare | input | W | Care mask, 1 = compared |
| wrTag | input | 4 | Layer tag of the entry |
| wrLen | input | LEN_W | Prefix length for the side-table |
| wrValid | input | 1 | Valid bit to store |
| rdEn | input | 1 | Read request |
| rdIdx | input | IDX_W | Entry index to read |
| busy | output | 1 | Write in progress |
| resValid | output | 1 | Search result strobe |
| resHit | output | 1 | Some entry matched |
| resIdx | output | IDX_W | Lowest matching index |
| rdDataValid | output | 1 | Read data strobe |
| rdValue | output | W | Read value bits |
| rdCare | output | W | Read care bits |
| rdTag | output | 4 | Read layer tag |
| rdLen | output | LEN_W | Read side-table length |
| rdEntryValid | output | 1 | Read valid bit |

## Verification
The assertions assume that a search and a commit never land on the same edge. The search-result check that reads the valid bit at `resIdx` depends on this, and the control guarantees it by accepting searches only while idle. They also assume that requests are only meaningful when out of reset. The stimulus changes inputs on the falling edge, holds each request for one cycle, and only issues searches during a write when the point is to show that they are dropped. Stored tags are always fully cared, matching how the write port encodes them.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int TAG_W = 4;

  typedef struct packed {
    logic searchGo;
    logic readGo;
    logic acceptWr;
    logic commitGo;
  } ctrl_strobes_t;
endpackage

// File: rtl/tcam_ctrl.sv
module tcam_ctrl #(
  parameter int WR_CYCLES = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   srchEn,
  input  logic                   wrEn,
  input  logic                   rdEn,
  output logic                   busy,
  output tcam_pkg::ctrl_strobes_t strobes
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cntQ;
  logic             idle;

  assign idle = (cntQ == '0);
  assign busy = !idle;

  always_comb begin
    strobes.searchGo = srchEn && idle;
    strobes.readGo   = rdEn;
    strobes.acceptWr = wrEn && idle;
    strobes.commitGo = (cntQ == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cntQ <= '0;
    else if (strobes.acceptWr) cntQ <= CNT_W'(WR_CYCLES);
    else if (!idle)            cntQ <= cntQ - CNT_W'(1);
  end

  // R8
  wr_busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy) |=> busy);
  // R8
  wr_commit_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitGo |=> !busy);
  // R9
  no_wr_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobes.commitGo) |=> busy);
endmodule

// File: rtl/tcam_maskgen.sv
module tcam_maskgen #(
  parameter int W = 8
) (
  input  logic [W-1:0]                    key,
  input  logic [$clog2(W+1)-1:0]          len,
  input  logic [tcam_pkg::TAG_W-1:0]      layer,
  output logic [W+tcam_pkg::TAG_W-1:0]    searchWord,
  output logic [W+tcam_pkg::TAG_W-1:0]    maskWord
);
  localparam int LEN_W = $clog2(W + 1);
  localparam int TAG_W = tcam_pkg::TAG_W;

  logic [LEN_W-1:0] effLen;

  assign effLen     = (len > LEN_W'(W)) ? LEN_W'(W) : len;
  assign searchWord = {layer, key};

  for (genvar i = 0; i < W; i++) begin : g_prefixCol
    assign maskWord[i] = (LEN_W'(W - i) <= effLen);
  end

  for (genvar t = 0; t < TAG_W; t++) begin : g_tagCol
    assign maskWord[W + t] = |layer;
  end
endmodule

// File: rtl/tcam_prienc.sv
module tcam_prienc #(
  parameter int N = 16
) (
  input  logic [N-1:0]         lines,
  output logic                 anyHit,
  output logic [$clog2(N)-1:0] hitIdx
);
  localparam int IDX_W = $clog2(N);

  assign anyHit = |lines;

  always_comb begin
    hitIdx = '0;
    for (int e = N - 1; e >= 0; e--) begin
      if (lines[e]) hitIdx = IDX_W'(e);
    end
  end

  // R5
  prienc_onehot_low_chk: assert final (!anyHit || lines[hitIdx]);
endmodule

// File: rtl/tcam_datapath.sv
module tcam_datapath #(
  parameter int W = 8,
  parameter int N = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tcam_pkg::ctrl_strobes_t       strobes,
  input  logic [W+tcam_pkg::TAG_W-1:0]  searchWord,
  input  logic [W+tcam_pkg::TAG_W-1:0]  maskWord,
  input  logic [$clog2(N)-1:0]          wrIdx,
  input  logic [W-1:0]                  wrValue,
  input  logic [W-1:0]                  wrCare,
  input  logic [tcam_pkg::TAG_W-1:0]    wrTag,
  input  logic [$clog2(W+1)-1:0]        wrLen,
  input  logic                          wrValid,
  input  logic [$clog2(N)-1:0]          rdIdx,
  output logic                          resValid,
  output logic                          resHit,
  output logic [$clog2(N)-1:0]          resIdx,
  output logic                          rdDataValid,
  output logic [W-1:0]                  rdValue,
  output logic [W-1:0]                  rdCare,
  output logic [tcam_pkg::TAG_W-1:0]    rdTag,
  output logic [$clog2(W+1)-1:0]        rdLen,
  output logic                          rdEntryValid
);
  localparam int TAG_W = tcam_pkg::TAG_W;
  localparam int EW    = W + TAG_W;
  localparam int IDX_W = $clog2(N);
  localparam int LEN_W = $clog2(W + 1);

  // two-bit cell code: 0 -> (d0=0,d1=1), 1 -> (1,0), don't care -> (1,1)
  logic [EW-1:0]    d0Q [N];
  logic [EW-1:0]    d1Q [N];
  logic [N-1:0]     validQ;
  logic [LEN_W-1:0] lenQ [N];

  logic [IDX_W-1:0] pendIdx;
  logic [EW-1:0]    pendD0, pendD1;
  logic             pendValid;
  logic [LEN_W-1:0] pendLen;

  logic [EW-1:0] wrWordVal, wrWordCare;
  assign wrWordVal  = {wrTag, wrValue};
  assign wrWordCare = {{TAG_W{1'b1}}, wrCare};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendIdx   <= '0;
      pendD0    <= '0;
      pendD1    <= '0;
      pendValid <= 1'b0;
      pendLen   <= '0;
    end else if (strobes.acceptWr) begin
      pendIdx   <= wrIdx;
      pendD0    <= wrWordVal | ~wrWordCare;
      pendD1    <= ~wrWordVal | ~wrWordCare;
      pendValid <= wrValid;
      pendLen   <= wrLen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int e = 0; e < N; e++) begin
        d0Q[e]  <= '0;
        d1Q[e]  <= '0;
        lenQ[e] <= '0;
      end
    end else if (strobes.commitGo) begin
      d0Q[pendIdx]    <= pendD0;
      d1Q[pendIdx]    <= pendD1;
      validQ[pendIdx] <= pendValid;
      lenQ[pendIdx]   <= pendLen;
    end
  end

  logic [N-1:0] matchLine;
  for (genvar e = 0; e < N; e++) begin : g_matchLine
    assign matchLine[e] = validQ[e] &
      (&(~maskWord | (searchWord & d0Q[e]) | (~searchWord & d1Q[e])));
  end

  logic             anyHit;
  logic [IDX_W-1:0] hitIdx;

  tcam_prienc #(.N(N)) u_prienc (
    .lines (matchLine),
    .anyHit(anyHit),
    .hitIdx(hitIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resHit   <= 1'b0;
      resIdx   <= '0;
    end else begin
      resValid <= strobes.searchGo;
      if (strobes.searchGo) begin
        resHit <= anyHit;
        resIdx <= hitIdx;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataValid  <= 1'b0;
      rdValue      <= '0;
      rdCare       <= '0;
      rdTag        <= '0;
      rdLen        <= '0;
      rdEntryValid <= 1'b0;
    end else begin
      rdDataValid <= strobes.readGo;
      if (strobes.readGo) begin
        rdValue      <= d0Q[rdIdx][W-1:0] & ~d1Q[rdIdx][W-1:0];
        rdCare       <= ~(d0Q[rdIdx][W-1:0] & d1Q[rdIdx][W-1:0]);
        rdTag        <= d0Q[rdIdx][EW-1:W] & ~d1Q[rdIdx][EW-1:W];
        rdLen        <= lenQ[rdIdx];
        rdEntryValid <= validQ[rdIdx];
      end
    end
  end

  // R7
  search_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.searchGo |=> resValid);
  // R6
  hit_entry_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit) |-> validQ[resIdx]);
  // R10
  read_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readGo |=> rdDataValid);
endmodule

// File: rtl/layer_tcam.sv
module layer_tcam #(
  parameter int W         = 8,
  parameter int N         = 16,
  parameter int WR_CYCLES = 3,
  localparam int LEN_W    = $clog2(W + 1),
  localparam int IDX_W    = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srchEn,
  input  logic [W-1:0]     srchKey,
  input  logic [LEN_W-1:0] srchLen,
  input  logic [3:0]       srchLayer,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [W-1:0]     wrValue,
  input  logic [W-1:0]     wrCare,
  input  logic [3:0]       wrTag,
  input  logic [LEN_W-1:0] wrLen,
  input  logic             wrValid,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             busy,
  output logic             resValid,
  output logic             resHit,
  output logic [IDX_W-1:0] resIdx,
  output logic             rdDataValid,
  output logic [W-1:0]     rdValue,
  output logic [W-1:0]     rdCare,
  output logic [3:0]       rdTag,
  output logic [LEN_W-1:0] rdLen,
  output logic             rdEntryValid
);
  localparam int EW = W + tcam_pkg::TAG_W;

  tcam_pkg::ctrl_strobes_t strobes;
  logic [EW-1:0] searchWord, maskWord;

  tcam_ctrl #(.WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .srchEn(srchEn), .wrEn(wrEn), .rdEn(rdEn),
    .busy(busy), .strobes(strobes)
  );

  tcam_maskgen #(.W(W)) u_maskgen (
    .key(srchKey), .len(srchLen), .layer(srchLayer),
    .searchWord(searchWord), .maskWord(maskWord)
  );

  tcam_datapath #(.W(W), .N(N)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .searchWord(searchWord), .maskWord(maskWord),
    .wrIdx(wrIdx), .wrValue(wrValue), .wrCare(wrCare), .wrTag(wrTag),
    .wrLen(wrLen), .wrValid(wrValid), .rdIdx(rdIdx),
    .resValid(resValid), .resHit(resHit), .resIdx(resIdx),
    .rdDataValid(rdDataValid), .rdValue(rdValue), .rdCare(rdCare),
    .rdTag(rdTag), .rdLen(rdLen), .rdEntryValid(rdEntryValid)
  );

  // R9
  drop_search_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && srchEn) |=> !resValid);
endmodule

// File: tb/layer_tcam_tb.sv
module layer_tcam_tb;
  localparam int W = 8;
  localparam int N = 16;

  logic clk = 0, rstN = 0;
  logic srchEn = 0, wrEn = 0, wrValid = 0, rdEn = 0;
  logic [W-1:0] srchKey = 0, wrValue = 0, wrCare = 0;
  logic [3:0] srchLen = 0, srchLayer = 0, wrTag = 0, wrLen = 0;
  logic [3:0] wrIdx = 0, rdIdx = 0;
  logic busy, resValid, resHit, rdDataValid, rdEntryValid;
  logic [3:0] resIdx, rdTag, rdLen;
  logic [W-1:0] rdValue, rdCare;

  int nChecks = 0, nFails = 0;

  logic [W-1:0] mVal [N];
  logic [W-1:0] mCare [N];
  logic [3:0]   mTag [N];
  logic [3:0]   mLen [N];
  logic         mValid [N];

  always #10 clk = ~clk;

  layer_tcam u_dut (.*);

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input logic [W-1:0] key, input logic [3:0] len,
                                input logic [3:0] lay, output int hit, output int idx);
    int eff;
    eff = (len > W) ? W : int'(len);
    hit = 0; idx = 0;
    for (int e = N - 1; e >= 0; e--) begin
      bit ok;
      ok = mValid[e] && (lay == 0 || mTag[e] == lay);
      for (int i = W - eff; i < W; i++)
        if (mCare[e][i] && mVal[e][i] != key[i]) ok = 0;
      if (ok) begin hit = 1; idx = e; end
    end
  endfunction

  task automatic doWrite(int idx, logic [W-1:0] v, logic [W-1:0] c,
                         logic [3:0] tag, logic [3:0] len, logic vld);
    int cnt = 0;
    @(negedge clk);
    wrEn = 1; wrIdx = 4'(idx); wrValue = v; wrCare = c; wrTag = tag;
    wrLen = len; wrValid = vld;
    @(negedge clk);
    wrEn = 0;
    while (busy && cnt < 10) begin cnt++; @(negedge clk); end
    chk("R8 busy cycles", cnt, 3);
    mVal[idx] = v & c; mCare[idx] = c; mTag[idx] = tag; mLen[idx] = len; mValid[idx] = vld;
  endtask

  task automatic doSearch(string req, logic [W-1:0] key, logic [3:0] len, logic [3:0] lay);
    int eh, ei;
    model(key, len, lay, eh, ei);
    @(negedge clk);
    srchEn = 1; srchKey = key; srchLen = len; srchLayer = lay;
    @(negedge clk);
    srchEn = 0;
    chk({req, " R7 resValid"}, int'(resValid), 1);
    chk({req, " hit"}, int'(resHit), eh);
    if (eh != 0) chk({req, " idx"}, int'(resIdx), ei);
  endtask

  task automatic doRead(string req, int idx);
    @(negedge clk);
    rdEn = 1; rdIdx = 4'(idx);
    @(negedge clk);
    rdEn = 0;
    chk({req, " R10 rdDataValid"}, int'(rdDataValid), 1);
    chk({req, " entry valid"}, int'(rdEntryValid), int'(mValid[idx]));
    if (mValid[idx]) begin
      chk({req, " R2 value"}, int'(rdValue), int'(mVal[idx]));
      chk({req, " R2 care"}, int'(rdCare), int'(mCare[idx]));
      chk({req, " tag"}, int'(rdTag), int'(mTag[idx]));
      chk({req, " R11 len"}, int'(rdLen), int'(mLen[idx]));
    end
  endtask

  task automatic testReset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 resValid", int'(resValid), 0);
    doSearch("R1 empty", 8'h00, 4'd8, 4'd0);
    chk("R1 resIdx", int'(resIdx), 0);
    doRead("R1 read", 5);
  endtask

  task automatic testFill();
    doWrite(2, 8'hA0, 8'hF0, 4'd1, 4'd4, 1);
    doWrite(5, 8'hAC, 8'hFC, 4'd1, 4'd6, 1);
    doWrite(9, 8'hA0, 8'hF0, 4'd2, 4'd4, 1);
    doWrite(12, 8'h33, 8'hFF, 4'd3, 4'd8, 0);
    doWrite(0, 8'h00, 8'h00, 4'd4, 4'd0, 1);
    doRead("R2 e2", 2);
    doRead("R11 e5", 5);
    doRead("R2 dontcare e0", 0);
  endtask

  task automatic testLayers();
    doSearch("R5 all layers lowest", 8'hAC, 4'd8, 4'd0);
    chk("R5 idx0", int'(resIdx), 0);
    doSearch("R4 layer1", 8'hAC, 4'd8, 4'd1);
    chk("R5 layer1 idx2", int'(resIdx), 2);
    doSearch("R4 layer2", 8'hAF, 4'd8, 4'd2);
    chk("R4 layer2 idx9", int'(resIdx), 9);
    doSearch("R6 invalid entry", 8'h33, 4'd8, 4'd3);
    chk("R6 miss", int'(resHit), 0);
    doSearch("R4 empty layer", 8'hAC, 4'd8, 4'd5);
    chk("R4 miss", int'(resHit), 0);
  endtask

  task automatic testPrefixLen();
    doSearch("R3 len4 hit", 8'hAF, 4'd4, 4'd1);
    doSearch("R3 len4 miss", 8'hB0, 4'd4, 4'd1);
    chk("R3 miss", int'(resHit), 0);
    doSearch("R3 len3 hit", 8'hB0, 4'd3, 4'd1);
    chk("R3 len3 idx", int'(resIdx), 2);
    doSearch("R3 len0", 8'h00, 4'd0, 4'd2);
    chk("R3 len0 idx", int'(resIdx), 9);
    doSearch("R3 len15 clamp", 8'hAD, 4'd15, 4'd1);
    doSearch("R3 e5 exact", 8'hAF, 4'd8, 4'd1);
    chk("R3 e5 miss-ish idx2", int'(resIdx), 2);
  endtask

  task automatic testBusyIgnore();
    int seen = 0;
    @(negedge clk);
    wrEn = 1; wrIdx = 4'd0; wrValue = 8'hFF; wrCare = 8'hFF; wrTag = 4'd4;
    wrLen = 4'd8; wrValid = 0;
    @(negedge clk);
    wrIdx = 4'd7; wrValid = 1;
    srchEn = 1; srchKey = 8'h00; srchLen = 4'd0; srchLayer = 4'd0;
    rdEn = 1; rdIdx = 4'd0;
    @(negedge clk);
    wrEn = 0; srchEn = 0; rdEn = 0;
    chk("R10 old data during write", int'(rdEntryValid), 1);
    seen += int'(resValid);
    @(negedge clk);
    seen += int'(resValid);
    @(negedge clk);
    chk("R9 no result while busy", seen, 0);
    chk("R8 busy ends", int'(busy), 0);
    mValid[0] = 0;
    doRead("R9 e7 untouched", 7);
    doSearch("R8 new contents", 8'hAC, 4'd8, 4'd0);
    chk("R8 idx2 after delete", int'(resIdx), 2);
  endtask

  initial begin
    for (int e = 0; e < N; e++) begin
      mVal[e] = 0; mCare[e] = 0; mTag[e] = 0; mLen[e] = 0; mValid[e] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testFill();
    testLayers();
    testPrefixLen();
    testBusyIgnore();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule